// File: doc/BRIEF.md
# Seven-to-One Multi-Lane Serializer

This transmitter takes a 21-bit parallel word once per frame and sends it over three serial data lanes, seven bits per lane, one bit per cycle of a bit clock that runs seven times faster than the frame clock. A fourth serial lane forwards the frame clock as a seven-slot pattern, so that a receiver can rebuild frame timing from the same lanes that carry the data. The bit clock is an input and is assumed to be phase-locked to the frame clock. The frame clock arrives as a level signal that the bit clock samples.

An active-low power-down input forces every serial output, and the lane-enable output, to zero at once. After power-down is released, or after reset, a lock-wait counter keeps the outputs idle for a settling interval counted in bit-clock cycles. Transmission then starts at the next frame boundary, so the first frame seen downstream is always a whole one.

Top module: `ser7_tx`

## Requirements
- R1: While rst_n is low, and after the synchronous reset, ser_data, ser_fwd and ser_en are all 0.
- R2: On the bit-clock edge where frame_clk is first seen high after being low, par_word is captured, and from that edge each lane shows its bit 0 while ser_fwd is 1.
- R3: Lane k (ser_data bit k) carries par_word bits 7k to 7k+6, least significant bit first, one bit per bit-clock cycle.
- R4: ser_fwd shows the pattern 1,1,1,1,0,0,0 over the seven slots of a frame, with slot 0 aligned to bit 0 of the data lanes.
- R5: Changes on par_word after the capture edge have no effect on the frame being sent.
- R6: A new word is loaded on the slot right after bit 6, so consecutive frames follow with no idle slot.
- R7: While pwr_n is low, ser_data, ser_fwd and ser_en are 0 with no clock edge needed.
- R8: After reset or a power-down ends, outputs stay idle until LOCK_CYCLES bit-clock edges have passed with pwr_n high. ser_en then rises at the next frame start, between LOCK_CYCLES+1 and LOCK_CYCLES+7 edges after release.
- R9: Asserting pwr_n during the wait restarts the lock count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit-rate clock, seven times the frame rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down |
| frame_clk | input | 1 | Frame clock, sampled by clk_bit |
| par_word | input | LANES*7 | Parallel word captured each frame |
| ser_data | output | LANES | Serial data lanes |
| ser_fwd | output | 1 | Forwarded frame-clock lane |
| ser_en | output | 1 | High while lanes are driven; low means idle |

## Verification
The hardest state to reach from the ports is a power-down that arrives part way through the lock wait. Only the timing of the later enable shows whether the count restarted, and the count itself is never visible. The bench releases power-down and waits about half the settling interval. It then pulses pwr_n low for a few cycles and measures the edges from the final release to the rise of ser_en. That number must be above LOCK_CYCLES, which a counter that only paused would fail. The bench also holds a free-running frame clock and scrambles par_word in the middle of frames, to show that only the captured word is sent.

// File: rtl/ser7_pkg.sv
// Shared constants and types for the seven-to-one serializer.
// Assumes the serialization ratio is fixed at seven slots per frame.
package ser7_pkg;
    localparam int SLOTS  = 7;
    localparam int SLOT_W = $clog2(SLOTS);
    typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/ser7_lock_gate.sv
// Lock-wait counter: counts bit clocks while power-down is released and
// reports when the settling interval has elapsed. Any power-down or reset
// restarts the count. Assumes LOCK_CYCLES >= 1.
module ser7_lock_gate #(
    parameter int LOCK_CYCLES = 1000
) (
    input  logic clk_bit,
    input  logic rst_n,
    input  logic pwr_n,
    output logic lock_done
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

    logic [CW-1:0] cnt;

    // Count up to the limit while powered, clear otherwise.
    always_ff @(posedge clk_bit) begin
        if (!rst_n || !pwr_n) cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign lock_done = (cnt == LIMIT);

    a_r9_restart: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !pwr_n |=> (cnt == '0));
    a_r8_bounded: assert property (@(posedge clk_bit) disable iff (!rst_n)
        cnt <= LIMIT);
endmodule

// File: rtl/ser7_frame_ctl.sv
// Frame control: samples the frame clock, finds its rising edge, keeps the
// slot counter and produces the per-frame load pulse and forwarded-clock
// bit. A load happens on a frame-clock rise or after slot 6, whichever
// comes first. Assumes frame_clk is synchronous to clk_bit.
module ser7_frame_ctl
    import ser7_pkg::*;
#(
    parameter int HIGH_SLOTS = 4
) (
    input  logic  clk_bit,
    input  logic  rst_n,
    input  logic  frame_clk,
    output logic  load,
    output slot_t slot,
    output logic  fwd
);
    localparam slot_t LAST = slot_t'(SLOTS - 1);
    localparam slot_t HIGH = slot_t'(HIGH_SLOTS);

    logic  fclk_q;
    logic  rise;
    slot_t slot_nx;

    assign rise    = frame_clk && !fclk_q;
    assign load    = rise || (slot == LAST);
    assign slot_nx = load ? '0 : slot + 1'b1;

    // Remember the previous frame-clock sample for edge detection.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) fclk_q <= 1'b0;
        else        fclk_q <= frame_clk;
    end

    // Advance the slot counter and the forwarded-clock pattern.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            slot <= LAST;
            fwd  <= 1'b0;
        end else begin
            slot <= slot_nx;
            fwd  <= (slot_nx < HIGH);
        end
    end

    a_r6_wrap: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (slot == LAST) |=> (slot == '0));
    a_r4_fall: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $fell(fwd) |-> (slot == HIGH));
    a_r2_rise: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (frame_clk && !fclk_q) |=> (slot == '0 && fwd));
endmodule

// File: rtl/ser7_lane.sv
// One serial data lane: on load, launch bit 0 of the lane's slice and keep
// the rest. Otherwise shift one bit out per bit clock, LSB first.
module ser7_lane
    import ser7_pkg::*;
(
    input  logic             clk_bit,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SLOTS-1:0] bits,
    output logic             ser
);
    logic [SLOTS-2:0] sh;

    // Load a fresh slice or shift toward the output.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            ser <= 1'b0;
            sh  <= '0;
        end else if (load) begin
            ser <= bits[0];
            sh  <= bits[SLOTS-1:1];
        end else begin
            ser <= sh[0];
            sh  <= {1'b0, sh[SLOTS-2:1]};
        end
    end

    a_r3_bit0: assert property (@(posedge clk_bit) disable iff (!rst_n)
        load |=> (ser == $past(bits[0])));
endmodule

// File: rtl/ser7_tx.sv
// Seven-to-one multi-lane serializer top. Splits par_word into LANES
// slices of seven bits, serializes each on its own lane, forwards the
// frame clock on a separate lane, and idles all outputs during power-down
// and the lock wait that follows. Enable starts only at a frame boundary.
module ser7_tx
    import ser7_pkg::*;
#(
    parameter int LANES       = 3,
    parameter int LOCK_CYCLES = 1000,
    parameter int HIGH_SLOTS  = 4
) (
    input  logic                   clk_bit,
    input  logic                   rst_n,
    input  logic                   pwr_n,
    input  logic                   frame_clk,
    input  logic [LANES*SLOTS-1:0] par_word,
    output logic [LANES-1:0]       ser_data,
    output logic                   ser_fwd,
    output logic                   ser_en
);
    logic             load;
    slot_t            slot;
    logic             fwd;
    logic             lock_done;
    logic             en_q;
    logic [LANES-1:0] lane_bit;

    ser7_lock_gate #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk_bit(clk_bit), .rst_n(rst_n), .pwr_n(pwr_n), .lock_done(lock_done)
    );

    ser7_frame_ctl #(.HIGH_SLOTS(HIGH_SLOTS)) u_frame (
        .clk_bit(clk_bit), .rst_n(rst_n), .frame_clk(frame_clk),
        .load(load), .slot(slot), .fwd(fwd)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        ser7_lane u_lane (
            .clk_bit(clk_bit), .rst_n(rst_n), .load(load),
            .bits(par_word[k*SLOTS +: SLOTS]), .ser(lane_bit[k])
        );
    end

    // Turn the lanes on at the first frame start after lock.
    always_ff @(posedge clk_bit) begin
        if (!rst_n || !pwr_n)      en_q <= 1'b0;
        else if (lock_done && load) en_q <= 1'b1;
    end

    assign ser_en   = en_q && pwr_n;
    assign ser_data = lane_bit & {LANES{ser_en}};
    assign ser_fwd  = fwd && ser_en;

    a_r8_start: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $rose(en_q) |-> (slot == '0));
    a_r8_locked: assert property (@(posedge clk_bit) disable iff (!rst_n)
        en_q |-> lock_done);
    a_r7_off: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !pwr_n |=> !en_q);
endmodule

// File: tb/ser7_tx_bench.sv
// Directed bench for ser7_tx: one task per scenario, each checking itself.
module ser7_tx_bench;
    localparam int L  = 40;
    localparam int NL = 3;

    logic          clk_bit = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_n = 1'b1;
    logic          frame_clk = 1'b0;
    logic [20:0]   par_word = '0;
    logic [NL-1:0] ser_data;
    logic          ser_fwd;
    logic          ser_en;

    int n_chk = 0;
    int n_bad = 0;
    int ph = 6;
    int fno = 0;
    bit glitch = 1'b0;
    logic [20:0] cur_word = '0;

    ser7_tx #(.LANES(NL), .LOCK_CYCLES(L)) u_ser7_tx (
        .clk_bit(clk_bit), .rst_n(rst_n), .pwr_n(pwr_n), .frame_clk(frame_clk),
        .par_word(par_word), .ser_data(ser_data), .ser_fwd(ser_fwd), .ser_en(ser_en)
    );

    always #5 clk_bit = ~clk_bit;

    function automatic logic [20:0] pat(int n);
        case (n % 5)
            0: pat = 21'h000000;
            1: pat = 21'h1FFFFF;
            2: pat = 21'h155555;
            3: pat = 21'h1 << (n % 21);
            default: pat = 21'(n * 40503 + 7);
        endcase
    endfunction

    // Free-running frame clock (4 high, 3 low) and word source.
    always @(negedge clk_bit) begin
        ph = (ph == 6) ? 0 : ph + 1;
        frame_clk = (ph < 4);
        if (ph == 0) begin
            fno++;
            cur_word = pat(fno);
            par_word = cur_word;
        end else if (glitch) begin
            par_word = ~cur_word ^ 21'(ph * 4099);
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic sample();
        @(posedge clk_bit);
        #3;
    endtask

    function automatic logic [4:0] seen();
        return {ser_en, ser_fwd, ser_data};
    endfunction

    function automatic logic [4:0] expect_slot();
        return {1'b1, (ph < 4) ? 1'b1 : 1'b0,
                cur_word[14+ph], cur_word[7+ph], cur_word[ph]};
    endfunction

    // R1: outputs idle during and right after reset.
    task automatic t_reset();
        repeat (4) sample();
        chk(seen() == 5'b0, "R1", 32'(seen()), 32'h0);
    endtask

    // R8: idle until lock, then enable at frame start within the window.
    task automatic t_wait_enable(string req);
        int n = 0;
        bit early = 1'b0;
        do begin
            sample();
            n++;
            if (!ser_en && seen() != 5'b0) early = 1'b1;
        end while (!ser_en && n < L + 20);
        chk(!early, req, 32'(early), 32'h0);
        chk(n >= L + 1 && n <= L + 7, req, 32'(n), 32'(L + 1));
        chk(ph == 0, "R2", 32'(ph), 32'h0);
        chk(seen() == expect_slot(), "R2", 32'(seen()), 32'(expect_slot()));
    endtask

    // R3 R4 R6: several back-to-back frames checked slot by slot.
    task automatic t_stream(string req, int slots);
        for (int i = 0; i < slots; i++) begin
            sample();
            chk(seen() == expect_slot(), req, 32'(seen()), 32'(expect_slot()));
        end
    endtask

    // R5: scramble par_word mid-frame; only captured word is sent.
    task automatic t_glitch();
        glitch = 1'b1;
        t_stream("R5", 21);
        glitch = 1'b0;
    endtask

    // R7: power-down idles outputs at once and for as long as held.
    task automatic t_powerdown();
        bit bad = 1'b0;
        pwr_n = 1'b0;
        #1;
        chk(seen() == 5'b0, "R7", 32'(seen()), 32'h0);
        for (int i = 0; i < 20; i++) begin
            sample();
            if (seen() != 5'b0) bad = 1'b1;
        end
        chk(!bad, "R7", 32'(bad), 32'h0);
        @(negedge clk_bit);
        pwr_n = 1'b1;
        t_wait_enable("R8");
    endtask

    // R9: a power-down pulse mid-wait restarts the full count.
    task automatic t_restart();
        @(negedge clk_bit);
        pwr_n = 1'b0;
        repeat (3) @(negedge clk_bit);
        pwr_n = 1'b1;
        repeat (L / 2) @(negedge clk_bit);
        pwr_n = 1'b0;
        repeat (3) @(negedge clk_bit);
        pwr_n = 1'b1;
        t_wait_enable("R9");
        t_stream("R9", 14);
    endtask

    initial begin
        t_reset();
        @(negedge clk_bit);
        rst_n = 1'b1;
        t_wait_enable("R8");
        t_stream("R3", 42);
        t_stream("R4", 21);
        t_stream("R6", 28);
        t_glitch();
        sample();
        t_powerdown();
        t_stream("R6", 14);
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule